// File: doc/BRIEF.md
# NAND Die Command Acceptance Tracker

This block is a behavioural model of one flash die as seen from the device side of an asynchronous command bus. It takes decoded bus cycles as input: a command strobe or an address strobe, each carrying one byte. For each command it decides whether the die can take it in its present state. It follows the address sequences that belong to each operation and keeps the two-level ready state. The first level, RDY, shows whether the cache register can accept a new operation. The second level, ARDY, shows whether the array is also idle.

Cache operations hand data from the cache register to the data register. The handoff takes a parameterised busy time. When an array operation is already running, the handoff also waits for that operation to finish. The die then stays RDY with ARDY low until the array work completes.

Accepted commands and rejected commands each produce a one-cycle pulse. A rejected command changes no state. The block also keeps a status byte, a ready/busy pin, a data-output-mode flag and the current column pointer, and it pulses a flag whenever the cache register contents are to be cleared.

Top module: `die_cmd_tracker`

## Requirements
- R1: After synchronous reset, the status byte is 0x60, rb_n is 1, dout_mode is 0, column_ptr is 0, and no pulse output is high.
- R2: The status byte has RDY at bit 6, ARDY at bit 5, FAILC at bit 1 and FAIL at bit 0, and all other bits are 0. rb_n equals RDY.
- R3: Each command strobe raises exactly one of cmd_acc or cmd_rej, for one cycle, in the cycle after the strobe. A rejected command changes no state. Opcodes outside the set 70h, 05h, E0h, 80h, 85h, 10h, 11h, 15h and 31h are rejected. 70h is accepted in every state.
- R4: 05h is accepted when RDY=1 and no sequence is open, and either ARDY=1 or a cache read is running. It must be followed by COL_CYC column address cycles, least significant byte first, and then E0h. That E0h is accepted and sets dout_mode. An E0h in any other situation is rejected.
- R5: dout_mode stays set until the next accepted command other than E0h. Rejected commands leave it set.
- R6: 80h is accepted when RDY=1 and no sequence is open, and either ARDY=1 or a cache program is running in the array. 80h is rejected in every other state, including during a cache read and during data input.
- R7: An accepted 80h pulses cache_clr together with cmd_acc, unless the last confirm accepted before it was 11h.
- R8: After 80h, ADDR_CYC address cycles follow, and the first COL_CYC of them load column_ptr, least significant byte first. The die then enters data input. In data input, 85h is accepted and reloads column_ptr from the next COL_CYC address cycles. 85h is rejected outside data input.
- R9: 10h, 11h and 15h are accepted only in data input. 11h closes the sequence without any busy time.
- R10: 10h drives RDY=0 and ARDY=0 from the cycle after the accept, for T_ARR+1 cycles when the array is idle, and then returns both to 1.
- R11: 15h drives RDY=0 and ARDY=0 for T_CBSY cycles. The die then shows RDY=1 and ARDY=0 for T_ARR cycles. If an earlier array program is still running, RDY stays 0 until one cycle after that program ends.
- R12: 31h is accepted only when RDY=1, ARDY=1 and no sequence is open. It has the same busy profile as 15h.
- R13: When an array program completes, FAILC takes the previous FAIL value and FAIL takes array_fail as sampled at the completion edge. Cache reads leave both bits unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_stb | input | 1 | Command cycle strobe |
| addr_stb | input | 1 | Address cycle strobe |
| io_byte | input | 8 | Byte carried by the current bus cycle |
| array_fail | input | 1 | Array program result, sampled when a program completes |
| status_byte | output | 8 | Die status byte |
| rb_n | output | 1 | Ready/busy, low while RDY=0 |
| dout_mode | output | 1 | Data output mode flag |
| cmd_acc | output | 1 | One-cycle pulse: command accepted |
| cmd_rej | output | 1 | One-cycle pulse: command rejected |
| cache_clr | output | 1 | One-cycle pulse: cache register clear |
| column_ptr | output | 8*COL_CYC | Current column pointer |

## Verification
The bench builds the block with T_CBSY=4, T_ARR=12, ADDR_CYC=5 and COL_CYC=2. These short busy windows let a second cache program be queued while the first still occupies the array. The handoff is then seen stretching past T_CBSY. The FAILC/FAIL shift is observed across back-to-back programs. A column change and an 80h rejection are exercised during a cache read, all within a few dozen cycles.

// File: rtl/die_trk_pkg.sv
package die_trk_pkg;

  localparam logic [7:0] OP_STATUS  = 8'h70;
  localparam logic [7:0] OP_COLSEL  = 8'h05;
  localparam logic [7:0] OP_COLGO   = 8'hE0;
  localparam logic [7:0] OP_LOAD    = 8'h80;
  localparam logic [7:0] OP_RELOC   = 8'h85;
  localparam logic [7:0] OP_COMMIT  = 8'h10;
  localparam logic [7:0] OP_PLANE   = 8'h11;
  localparam logic [7:0] OP_CCOMMIT = 8'h15;
  localparam logic [7:0] OP_CREAD   = 8'h31;

  // Where the die is inside a multi-cycle command sequence.
  typedef enum logic [2:0] {
    PH_IDLE,
    PH_LADDR,   // address cycles after 80h
    PH_DIN,     // data input phase
    PH_RELOC,   // column cycles after 85h
    PH_CSEL,    // column cycles after 05h
    PH_CGO      // waiting for E0h
  } phase_t;

  typedef enum logic [1:0] {
    BZ_CPROG,   // cache program handoff
    BZ_FULL,    // plain program, array busy blocks RDY
    BZ_CREAD    // cache read handoff
  } busy_kind_t;

endpackage

// File: rtl/die_cmd_gate.sv
module die_cmd_gate
  import die_trk_pkg::*;
(
  input  logic [7:0] op,
  input  phase_t     phase,
  input  logic       rdy,
  input  logic       ardy,
  input  logic       cprog_run,
  input  logic       cread_run,
  output logic       ok,
  output logic       start,
  output busy_kind_t kind
);

  logic seq_free;
  assign seq_free = (phase == PH_IDLE);

  always_comb begin
    ok    = 1'b0;
    start = 1'b0;
    kind  = BZ_FULL;
    case (op)
      OP_STATUS:  ok = 1'b1;
      OP_COLSEL:  ok = rdy && seq_free && (ardy || cread_run);
      OP_COLGO:   ok = (phase == PH_CGO);
      OP_LOAD:    ok = rdy && seq_free && (ardy || cprog_run);
      OP_RELOC:   ok = (phase == PH_DIN);
      OP_PLANE:   ok = (phase == PH_DIN);
      OP_COMMIT: begin
        ok    = (phase == PH_DIN);
        start = ok;
        kind  = BZ_FULL;
      end
      OP_CCOMMIT: begin
        ok    = (phase == PH_DIN);
        start = ok;
        kind  = BZ_CPROG;
      end
      OP_CREAD: begin
        ok    = rdy && ardy && seq_free;
        start = ok;
        kind  = BZ_CREAD;
      end
      default:    ok = 1'b0;
    endcase
  end

endmodule

// File: rtl/die_busy_timer.sv
module die_busy_timer
  import die_trk_pkg::*;
#(
  parameter int T_CBSY = 60,
  parameter int T_ARR  = 400
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  input  busy_kind_t kind,
  output logic       rdy,
  output logic       ardy,
  output logic       cprog_run,
  output logic       cread_run,
  output logic       prog_done
);

  localparam int HW = (T_CBSY > 1) ? $clog2(T_CBSY) : 1;
  localparam int AW = (T_ARR > 1) ? $clog2(T_ARR) : 1;
  localparam logic [HW-1:0] HAND_MAX = HW'(T_CBSY - 1);
  localparam logic [AW-1:0] ARR_MAX  = AW'(T_ARR - 1);

  logic          hand_act, pend_full, pend_prog;
  logic [HW-1:0] hand_cnt;
  logic          arr_act, arr_full, arr_prog;
  logic [AW-1:0] arr_cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      hand_act  <= 1'b0;
      hand_cnt  <= '0;
      pend_full <= 1'b0;
      pend_prog <= 1'b0;
      arr_act   <= 1'b0;
      arr_cnt   <= '0;
      arr_full  <= 1'b0;
      arr_prog  <= 1'b0;
    end else begin
      if (arr_act) begin
        if (arr_cnt == '0) arr_act <= 1'b0;
        else               arr_cnt <= arr_cnt - 1'b1;
      end
      // Handoff ends only once its own time is spent and the array is free.
      if (hand_act) begin
        if (hand_cnt != '0) begin
          hand_cnt <= hand_cnt - 1'b1;
        end else if (!arr_act) begin
          hand_act <= 1'b0;
          arr_act  <= 1'b1;
          arr_cnt  <= ARR_MAX;
          arr_full <= pend_full;
          arr_prog <= pend_prog;
        end
      end
      if (start) begin
        hand_act  <= 1'b1;
        hand_cnt  <= (kind == BZ_FULL) ? '0 : HAND_MAX;
        pend_full <= (kind == BZ_FULL);
        pend_prog <= (kind != BZ_CREAD);
      end
    end
  end

  assign rdy       = !hand_act && !(arr_act && arr_full);
  assign ardy      = !hand_act && !arr_act;
  assign cprog_run = arr_act && arr_prog && !arr_full;
  assign cread_run = arr_act && !arr_prog;
  assign prog_done = arr_act && (arr_cnt == '0) && arr_prog;

  // R10/R11: the array only starts out of a handoff
  a_r11_arr_after_handoff: assert property (@(posedge clk) disable iff (rst)
    $rose(arr_act) |-> $past(hand_act));

  // R3: a new busy phase is never launched on top of a running handoff
  a_r10_start_when_free: assert property (@(posedge clk) disable iff (rst)
    start |-> !hand_act);

  // R11: a waiting handoff holds while the array is still running
  a_r11_hold_while_array: assert property (@(posedge clk) disable iff (rst)
    (hand_act && arr_act && arr_cnt != '0) |=> hand_act);

endmodule

// File: rtl/die_status_reg.sv
module die_status_reg (
  input  logic       clk,
  input  logic       rst,
  input  logic       rdy,
  input  logic       ardy,
  input  logic       prog_done,
  input  logic       array_fail,
  output logic [7:0] status_byte
);

  logic fail_q, failc_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      fail_q  <= 1'b0;
      failc_q <= 1'b0;
    end else if (prog_done) begin
      failc_q <= fail_q;
      fail_q  <= array_fail;
    end
  end

  assign status_byte = {1'b0, rdy, ardy, 3'b000, failc_q, fail_q};

  // R13: fail bits move only on a program completion
  a_r13_fail_hold: assert property (@(posedge clk) disable iff (rst)
    !prog_done |=> $stable({failc_q, fail_q}));

endmodule

// File: rtl/die_cmd_tracker.sv
module die_cmd_tracker
  import die_trk_pkg::*;
#(
  parameter int T_CBSY   = 60,
  parameter int T_ARR    = 400,
  parameter int ADDR_CYC = 5,
  parameter int COL_CYC  = 2
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 cmd_stb,
  input  logic                 addr_stb,
  input  logic [7:0]           io_byte,
  input  logic                 array_fail,
  output logic [7:0]           status_byte,
  output logic                 rb_n,
  output logic                 dout_mode,
  output logic                 cmd_acc,
  output logic                 cmd_rej,
  output logic                 cache_clr,
  output logic [8*COL_CYC-1:0] column_ptr
);

  localparam int IW = $clog2(ADDR_CYC + 1);
  localparam logic [IW-1:0] LADDR_LAST = IW'(ADDR_CYC - 1);
  localparam logic [IW-1:0] COL_LAST   = IW'(COL_CYC - 1);

  phase_t             phase;
  logic [IW-1:0]      idx;
  logic [8*COL_CYC-1:0] col_q;
  logic               two_plane;
  logic               dout_q, acc_q, rej_q, clr_q;

  logic       rdy, ardy, cprog_run, cread_run, prog_done;
  logic       g_ok, g_start;
  busy_kind_t g_kind;
  logic       take;

  die_cmd_gate u_gate (
    .op        (io_byte),
    .phase     (phase),
    .rdy       (rdy),
    .ardy      (ardy),
    .cprog_run (cprog_run),
    .cread_run (cread_run),
    .ok        (g_ok),
    .start     (g_start),
    .kind      (g_kind)
  );

  die_busy_timer #(.T_CBSY(T_CBSY), .T_ARR(T_ARR)) u_timer (
    .clk       (clk),
    .rst       (rst),
    .start     (cmd_stb && g_start),
    .kind      (g_kind),
    .rdy       (rdy),
    .ardy      (ardy),
    .cprog_run (cprog_run),
    .cread_run (cread_run),
    .prog_done (prog_done)
  );

  die_status_reg u_status (
    .clk         (clk),
    .rst         (rst),
    .rdy         (rdy),
    .ardy        (ardy),
    .prog_done   (prog_done),
    .array_fail  (array_fail),
    .status_byte (status_byte)
  );

  assign take = cmd_stb && g_ok;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase     <= PH_IDLE;
      idx       <= '0;
      col_q     <= '0;
      two_plane <= 1'b0;
      dout_q    <= 1'b0;
      acc_q     <= 1'b0;
      rej_q     <= 1'b0;
      clr_q     <= 1'b0;
    end else begin
      acc_q <= take;
      rej_q <= cmd_stb && !g_ok;
      clr_q <= take && (io_byte == OP_LOAD) && !two_plane;
      if (take) begin
        dout_q <= (io_byte == OP_COLGO);
        case (io_byte)
          OP_COLSEL: begin phase <= PH_CSEL;  idx <= '0; end
          OP_LOAD:   begin phase <= PH_LADDR; idx <= '0; two_plane <= 1'b0; end
          OP_RELOC:  begin phase <= PH_RELOC; idx <= '0; end
          OP_PLANE:  begin phase <= PH_IDLE;  two_plane <= 1'b1; end
          OP_COLGO, OP_COMMIT, OP_CCOMMIT: phase <= PH_IDLE;
          default: ;
        endcase
      end else if (addr_stb && !cmd_stb) begin
        if (phase == PH_LADDR || phase == PH_RELOC || phase == PH_CSEL) begin
          for (int b = 0; b < COL_CYC; b++) begin
            if (idx == IW'(b)) col_q[b*8 +: 8] <= io_byte;
          end
          idx <= idx + 1'b1;
          if (phase == PH_LADDR && idx == LADDR_LAST) begin
            phase <= PH_DIN;
            idx   <= '0;
          end else if (phase != PH_LADDR && idx == COL_LAST) begin
            phase <= (phase == PH_RELOC) ? PH_DIN : PH_CGO;
            idx   <= '0;
          end
        end
      end
    end
  end

  assign rb_n       = rdy;
  assign dout_mode  = dout_q;
  assign cmd_acc    = acc_q;
  assign cmd_rej    = rej_q;
  assign cache_clr  = clr_q;
  assign column_ptr = col_q;

  // R3: accept and reject never coincide
  a_r3_one_verdict: assert property (@(posedge clk) disable iff (rst)
    !(cmd_acc && cmd_rej));

  // R3: every verdict pulse traces back to a command strobe
  a_r3_pulse_cause: assert property (@(posedge clk) disable iff (rst)
    (cmd_acc || cmd_rej) |-> $past(cmd_stb));

  // R7: a cache clear only comes with an accepted command
  a_r7_clr_with_accept: assert property (@(posedge clk) disable iff (rst)
    cache_clr |-> cmd_acc);

  // R5: output mode only switches on with an accepted command
  a_r5_dout_on_accept: assert property (@(posedge clk) disable iff (rst)
    $rose(dout_mode) |-> cmd_acc);

  // R5: a rejected command never changes output mode
  a_r5_dout_kept_on_reject: assert property (@(posedge clk) disable iff (rst)
    cmd_rej |-> $stable(dout_mode));

endmodule

// File: tb/die_cmd_tracker_tb.sv
`timescale 1ns/1ps
module die_cmd_tracker_tb;

  localparam int K_PULSE = 0, K_STAT = 1, K_RBN = 2, K_DOUT = 3, K_COL = 4;

  typedef struct {
    int    kind;
    int    val;
    int    due;
    string req;
  } exp_t;

  logic        clk = 1'b0;
  logic        rst, cmd_stb, addr_stb, array_fail;
  logic [7:0]  io_byte;
  logic [7:0]  status_byte;
  logic        rb_n, dout_mode, cmd_acc, cmd_rej, cache_clr;
  logic [15:0] column_ptr;

  int   cyc = 0;
  int   n_run = 0;
  int   n_fail = 0;
  int   act_v;
  bit   done = 1'b0;
  exp_t q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  die_cmd_tracker #(.T_CBSY(4), .T_ARR(12), .ADDR_CYC(5), .COL_CYC(2)) u_dut (
    .clk(clk), .rst(rst), .cmd_stb(cmd_stb), .addr_stb(addr_stb),
    .io_byte(io_byte), .array_fail(array_fail), .status_byte(status_byte),
    .rb_n(rb_n), .dout_mode(dout_mode), .cmd_acc(cmd_acc), .cmd_rej(cmd_rej),
    .cache_clr(cache_clr), .column_ptr(column_ptr)
  );

  // Monitor: pops every expectation that falls due at this falling edge.
  always @(negedge clk) begin
    for (int i = q.size() - 1; i >= 0; i--) begin
      if (q[i].due <= cyc) begin
        case (q[i].kind)
          K_PULSE: act_v = {cmd_acc, cmd_rej, cache_clr};
          K_STAT:  act_v = status_byte;
          K_RBN:   act_v = rb_n;
          K_DOUT:  act_v = dout_mode;
          default: act_v = column_ptr;
        endcase
        n_run++;
        if (act_v != q[i].val) begin
          n_fail++;
          $display("FAIL %s kind=%0d actual=0x%0h expected=0x%0h (cycle %0d)",
                   q[i].req, q[i].kind, act_v, q[i].val, cyc);
        end
        q.delete(i);
      end
    end
  end

  task automatic chk(input int kind, input int val, input int d, input string req);
    exp_t e;
    e.kind = kind; e.val = val; e.due = cyc + d; e.req = req;
    q.push_back(e);
  endtask

  task automatic idle(input int n);
    repeat (n) begin @(negedge clk); #1; end
  endtask

  task automatic cmd(input logic [7:0] op, input bit acc, input bit clr, input string req);
    cmd_stb = 1'b1; io_byte = op;
    chk(K_PULSE, {acc, !acc, clr}, 1, req);
    @(negedge clk); #1;
    cmd_stb = 1'b0;
  endtask

  task automatic adr(input logic [7:0] b);
    addr_stb = 1'b1; io_byte = b;
    @(negedge clk); #1;
    addr_stb = 1'b0;
  endtask

  initial begin
    rst = 1'b1; cmd_stb = 1'b0; addr_stb = 1'b0; io_byte = 8'h00; array_fail = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst = 1'b0;
    chk(K_STAT, 8'h60, 1, "R1"); chk(K_RBN, 1, 1, "R1");
    chk(K_DOUT, 0, 1, "R1");     chk(K_PULSE, 0, 1, "R1"); chk(K_COL, 0, 1, "R1");
    idle(2);

    // Status, unknown opcode, column change into output mode
    cmd(8'h70, 1, 0, "R3");
    cmd(8'h55, 0, 0, "R3");
    cmd(8'hE0, 0, 0, "R4");
    cmd(8'h05, 1, 0, "R4");
    adr(8'h34); adr(8'h12);
    cmd(8'hE0, 1, 0, "R4");
    chk(K_DOUT, 1, 1, "R5"); chk(K_COL, 16'h1234, 1, "R4");
    cmd(8'h55, 0, 0, "R5");
    chk(K_DOUT, 0, 1, "R5");
    cmd(8'h70, 1, 0, "R5");

    // Plain program with column relocation
    cmd(8'h85, 0, 0, "R8");
    cmd(8'h10, 0, 0, "R9");
    cmd(8'h80, 1, 1, "R7");
    adr(8'h10); adr(8'h00); adr(8'h01); adr(8'h02); adr(8'h03);
    chk(K_COL, 16'h0010, 1, "R8");
    cmd(8'h80, 0, 0, "R6");
    cmd(8'h85, 1, 0, "R8");
    adr(8'h22); adr(8'h01);
    chk(K_COL, 16'h0122, 1, "R8");
    array_fail = 1'b1;
    chk(K_STAT, 8'h00, 1, "R10"); chk(K_RBN, 0, 1, "R2");
    cmd(8'h10, 1, 0, "R10");
    cmd(8'h80, 0, 0, "R6");
    cmd(8'h31, 0, 0, "R12");
    chk(K_STAT, 8'h00, 10, "R10");
    chk(K_STAT, 8'h61, 11, "R13"); chk(K_RBN, 1, 11, "R2");
    idle(12);
    array_fail = 1'b0;

    // Cache program, then a second one queued behind the running array
    cmd(8'h80, 1, 1, "R7");
    adr(8'h00); adr(8'h00); adr(8'h05); adr(8'h06); adr(8'h07);
    chk(K_STAT, 8'h01, 1, "R11");
    cmd(8'h15, 1, 0, "R11");
    chk(K_STAT, 8'h01, 3, "R11");
    chk(K_STAT, 8'h41, 4, "R11");
    idle(4);
    cmd(8'h05, 0, 0, "R4");
    cmd(8'h80, 1, 1, "R6");
    adr(8'h00); adr(8'h00); adr(8'h08); adr(8'h09); adr(8'h0A);
    cmd(8'h15, 1, 0, "R11");
    chk(K_STAT, 8'h02, 4, "R11");
    chk(K_STAT, 8'h42, 5, "R13");
    chk(K_STAT, 8'h42, 16, "R11");
    chk(K_STAT, 8'h60, 17, "R13");
    idle(18);

    // Two-plane prelude suppresses the next clear once
    cmd(8'h80, 1, 1, "R7");
    adr(8'h00); adr(8'h00); adr(8'h01); adr(8'h00); adr(8'h00);
    chk(K_STAT, 8'h60, 1, "R9");
    cmd(8'h11, 1, 0, "R9");
    cmd(8'h80, 1, 0, "R7");
    adr(8'h00); adr(8'h00); adr(8'h02); adr(8'h00); adr(8'h00);
    cmd(8'h10, 1, 0, "R10");
    idle(14);
    chk(K_STAT, 8'h60, 1, "R10");
    cmd(8'h80, 1, 1, "R7");
    adr(8'h00); adr(8'h00); adr(8'h03); adr(8'h00); adr(8'h00);
    cmd(8'h11, 1, 0, "R9");

    // Cache read: column change allowed, program start refused
    array_fail = 1'b1;
    chk(K_STAT, 8'h00, 1, "R12");
    cmd(8'h31, 1, 0, "R12");
    chk(K_STAT, 8'h00, 3, "R12");
    chk(K_STAT, 8'h40, 4, "R12");
    idle(4);
    cmd(8'h80, 0, 0, "R6");
    cmd(8'h05, 1, 0, "R4");
    adr(8'h05); adr(8'h00);
    chk(K_DOUT, 1, 1, "R4"); chk(K_COL, 16'h0005, 1, "R4");
    cmd(8'hE0, 1, 0, "R4");
    chk(K_STAT, 8'h40, 6, "R12");
    chk(K_STAT, 8'h60, 7, "R13"); chk(K_DOUT, 1, 7, "R5");
    idle(9);

    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

endmodule